// File: doc/BRIEF.md
# Nested Prioritized Core Event Controller

This block sits beside a processor core and decides which pending event the core should service next. It accepts five classes of event: emulation entry, a reset request, a non-maskable interrupt, a synchronous exception, and nine general-purpose interrupt lines. Each event has a fixed level number from 0 to 15. A lower number means a higher priority. Levels 4 to 6 are never used. The block reports one winning level to the core through a grant strobe and a level number.

Handlers can nest. The block keeps one active bit for each level that the core has entered and not yet left. A new event is granted only if its priority is strictly above the highest level that is already active. An event that is not granted stays latched as pending until it wins. The core ends its current handler with a one-cycle return pulse, which closes the highest-priority active level. The general-purpose levels have their own enable bits. The two lowest levels, 14 and 15, are meant for software-raised work.

Grant decisions are combinational on the current state and inputs. An exception can therefore be accepted in the same cycle its strobe is raised. Pending, active and enable state are registered.

Top module: `core_event_ctrl`

## Requirements
- R1: While rst_n is low, grant_valid is 0 and active_levels is 0. In the first cycle after rst_n rises, grant_valid is 1 with grant_level 1, the reset event. All general-purpose enables come out of reset as 0.
- R2: When several eligible events are present together, the lowest level number wins. The levels are emulation 0, reset 1, NMI 2, exception 3, and general-purpose 7 to 15.
- R3: The NMI (level 2) is requested when any of wdog_nmi, pin_nmi or sw_nmi is high. The general-purpose enable bits have no effect on it.
- R4: If no level in 0..3 is active and nothing of higher priority is pending, exc_strobe produces grant_valid with grant_level 3 in the same cycle.
- R5: A grant happens only when the candidate level number is strictly below cur_level, or when no level is active. A request that does not meet this stays pending.
- R6: A grant sets active_levels[grant_level] at the next clock edge. cur_valid is then 1, and cur_level is the lowest active level number.
- R7: A ret_pulse clears the lowest-numbered active bit at the next clock edge. A pending lower-priority event may be granted in the cycle after that.
- R8: Writing with en_wr loads en_wdata into the general-purpose enables. Bit i enables level 7+i. A disabled level latches its request as pending but is never granted. It is granted once it is enabled.
- R9: A pending bit clears when its level is granted. A one-cycle request therefore produces exactly one grant.
- R10: irq_in[i] requests level 7+i. Levels 4, 5 and 6 are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_req | input | 1 | Emulation entry request (level 0) |
| rst_req | input | 1 | Reset event request (level 1) |
| wdog_nmi | input | 1 | Watchdog timeout NMI source |
| pin_nmi | input | 1 | External NMI source |
| sw_nmi | input | 1 | Software-raised NMI source |
| exc_strobe | input | 1 | Synchronous exception strobe (level 3) |
| irq_in | input | 9 | General-purpose requests; bit i is level 7+i |
| en_wr | input | 1 | Write strobe for the general-purpose enables |
| en_wdata | input | 9 | New enable value; bit i enables level 7+i |
| ret_pulse | input | 1 | Handler return from the core |
| grant_valid | output | 1 | A level is granted this cycle |
| grant_level | output | 4 | Granted level number |
| active_levels | output | 16 | One bit per level currently in service |
| cur_valid | output | 1 | At least one level is active |
| cur_level | output | 4 | Highest-priority active level |

## Verification
The grant is combinational. For an event that wins, grant_valid and grant_level are due in the same cycle the request is driven. The bench drives inputs just after a rising edge and samples at the following falling edge. A scoreboard queue holds the expected grant levels in order, and a monitor pops one at every falling edge where grant_valid is high. active_levels and cur_level change one edge after a grant or a return, so the bench checks them a full cycle later. A pending event released by a return is granted one cycle after that return, and the queue order alone pins down which event should appear.

// File: rtl/cec_pkg.sv
package cec_pkg;

    localparam int LEVELS  = 16;
    localparam int NUM_GP  = 9;
    localparam int GP_BASE = 7;
    localparam int LVL_EMU = 0;
    localparam int LVL_RST = 1;
    localparam int LVL_NMI = 2;
    localparam int LVL_EXC = 3;

    // Levels that can ever be requested: fixed classes plus the general-purpose band.
    function automatic logic [LEVELS-1:0] used_levels(input int base, input int num);
        logic [LEVELS-1:0] m;
        m = '0;
        m[LVL_EMU] = 1'b1;
        m[LVL_RST] = 1'b1;
        m[LVL_NMI] = 1'b1;
        m[LVL_EXC] = 1'b1;
        for (int i = 0; i < LEVELS; i++) begin
            if (i >= base && i < base + num) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cec_prio_pick.sv
module cec_prio_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    // The lowest set index wins, because a lower level number is a higher priority.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/cec_req_gather.sv
module cec_req_gather #(
    parameter int LEVELS  = 16,
    parameter int NUM_GP  = 9,
    parameter int GP_BASE = 7,
    parameter int L_EMU   = 0,
    parameter int L_RST   = 1,
    parameter int L_NMI   = 2,
    parameter int L_EXC   = 3
) (
    input  logic              emu_req,
    input  logic              rst_req,
    input  logic              wdog_nmi,
    input  logic              pin_nmi,
    input  logic              sw_nmi,
    input  logic              exc_strobe,
    input  logic [NUM_GP-1:0] irq_in,
    input  logic [NUM_GP-1:0] en_q,
    input  logic [LEVELS-1:0] pend_q,
    output logic [LEVELS-1:0] new_req,
    output logic [LEVELS-1:0] eligible
);
    localparam logic [LEVELS-1:0] USED = cec_pkg::used_levels(GP_BASE, NUM_GP);

    logic [LEVELS-1:0] fixed_req;
    logic [LEVELS-1:0] gp_req;
    logic [LEVELS-1:0] gp_en;
    logic [LEVELS-1:0] fixed_en;
    logic              nmi_any;

    assign nmi_any = wdog_nmi | pin_nmi | sw_nmi;

    always_comb begin
        fixed_req        = '0;
        fixed_req[L_EMU] = emu_req;
        fixed_req[L_RST] = rst_req;
        fixed_req[L_NMI] = nmi_any;
        fixed_req[L_EXC] = exc_strobe;
        fixed_en         = '0;
        fixed_en[L_EMU]  = 1'b1;
        fixed_en[L_RST]  = 1'b1;
        fixed_en[L_NMI]  = 1'b1;
        fixed_en[L_EXC]  = 1'b1;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (g >= GP_BASE && g < GP_BASE + NUM_GP) begin : g_gp
            assign gp_req[g] = irq_in[g - GP_BASE];
            assign gp_en[g]  = en_q[g - GP_BASE];
        end else begin : g_none
            assign gp_req[g] = 1'b0;
            assign gp_en[g]  = 1'b0;
        end
    end

    assign new_req  = (fixed_req | gp_req) & USED;
    assign eligible = (pend_q | new_req) & (fixed_en | gp_en) & USED;

endmodule

// File: rtl/core_event_ctrl.sv
module core_event_ctrl #(
    parameter int LEVELS  = cec_pkg::LEVELS,
    parameter int NUM_GP  = cec_pkg::NUM_GP,
    parameter int GP_BASE = cec_pkg::GP_BASE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      emu_req,
    input  logic                      rst_req,
    input  logic                      wdog_nmi,
    input  logic                      pin_nmi,
    input  logic                      sw_nmi,
    input  logic                      exc_strobe,
    input  logic [NUM_GP-1:0]         irq_in,
    input  logic                      en_wr,
    input  logic [NUM_GP-1:0]         en_wdata,
    input  logic                      ret_pulse,
    output logic                      grant_valid,
    output logic [$clog2(LEVELS)-1:0] grant_level,
    output logic [LEVELS-1:0]         active_levels,
    output logic                      cur_valid,
    output logic [$clog2(LEVELS)-1:0] cur_level
);
    localparam int LW = $clog2(LEVELS);

    typedef struct packed {
        logic [LEVELS-1:0] pend;
        logic [LEVELS-1:0] active;
        logic [NUM_GP-1:0] en;
    } cec_state_t;

    localparam cec_state_t RESET_STATE = '{
        pend:   LEVELS'(1) << cec_pkg::LVL_RST,
        active: '0,
        en:     '0
    };

    cec_state_t st_d, st_q;

    logic [LEVELS-1:0] new_req;
    logic [LEVELS-1:0] eligible;
    logic              cand_found;
    logic [LW-1:0]     cand_idx;
    logic              top_found;
    logic [LW-1:0]     top_idx;
    logic              win;

    cec_req_gather #(
        .LEVELS (LEVELS),
        .NUM_GP (NUM_GP),
        .GP_BASE(GP_BASE),
        .L_EMU  (cec_pkg::LVL_EMU),
        .L_RST  (cec_pkg::LVL_RST),
        .L_NMI  (cec_pkg::LVL_NMI),
        .L_EXC  (cec_pkg::LVL_EXC)
    ) gather_i (
        .emu_req   (emu_req),
        .rst_req   (rst_req),
        .wdog_nmi  (wdog_nmi),
        .pin_nmi   (pin_nmi),
        .sw_nmi    (sw_nmi),
        .exc_strobe(exc_strobe),
        .irq_in    (irq_in),
        .en_q      (st_q.en),
        .pend_q    (st_q.pend),
        .new_req   (new_req),
        .eligible  (eligible)
    );

    cec_prio_pick #(.W(LEVELS)) cand_pick_i (
        .vec  (eligible),
        .found(cand_found),
        .idx  (cand_idx)
    );

    cec_prio_pick #(.W(LEVELS)) top_pick_i (
        .vec  (st_q.active),
        .found(top_found),
        .idx  (top_idx)
    );

    // Preemption needs a strictly higher priority (a smaller index) than the running level.
    assign win = rst_n && cand_found && (!top_found || (cand_idx < top_idx));

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | new_req;
        if (win) begin
            st_d.pend[cand_idx] = 1'b0;
        end
        if (ret_pulse && top_found) begin
            st_d.active[top_idx] = 1'b0;
        end
        if (win) begin
            st_d.active[cand_idx] = 1'b1;
        end
        if (en_wr) begin
            st_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign grant_valid   = win;
    assign grant_level   = cand_idx;
    assign active_levels = st_q.active;
    assign cur_valid     = top_found;
    assign cur_level     = top_idx;

    a_r5_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && cur_valid) |-> (grant_level < cur_level));

    a_r6_grant_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> active_levels[$past(grant_level)]);

    a_r7_return_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && cur_valid && !grant_valid) |=>
            ($countones(active_levels) == $countones($past(active_levels)) - 1));

    a_r4_exception_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_strobe && (active_levels[3:0] == 4'b0)) |-> (grant_valid && (grant_level <= 4'd3)));

    a_r10_no_unused_level: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant_level < 4'd4) || (grant_level >= LW'(GP_BASE))));

    a_r8_disabled_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.pend[GP_BASE +: NUM_GP]) & ~$past(st_q.en)
                   & ~st_q.pend[GP_BASE +: NUM_GP]) == '0));

endmodule

// File: tb/core_event_ctrl_tb_top.sv
module core_event_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        emu_req, rst_req, wdog_nmi, pin_nmi, sw_nmi, exc_strobe;
    logic [8:0]  irq_in;
    logic        en_wr;
    logic [8:0]  en_wdata;
    logic        ret_pulse;
    logic        grant_valid;
    logic [3:0]  grant_level;
    logic [15:0] active_levels;
    logic        cur_valid;
    logic [3:0]  cur_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    core_event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .rst_req(rst_req),
        .wdog_nmi(wdog_nmi), .pin_nmi(pin_nmi), .sw_nmi(sw_nmi),
        .exc_strobe(exc_strobe), .irq_in(irq_in), .en_wr(en_wr),
        .en_wdata(en_wdata), .ret_pulse(ret_pulse), .grant_valid(grant_valid),
        .grant_level(grant_level), .active_levels(active_levels),
        .cur_valid(cur_valid), .cur_level(cur_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int lvl);
        exp_q.push_back(lvl);
    endtask

    task automatic pulse_irq(input int bitn);
        tick();
        irq_in[bitn] = 1'b1;
        tick();
        irq_in = '0;
    endtask

    task automatic do_ret();
        tick();
        ret_pulse = 1'b1;
        tick();
        ret_pulse = 1'b0;
    endtask

    task automatic write_en(input logic [8:0] v);
        tick();
        en_wr = 1'b1;
        en_wdata = v;
        tick();
        en_wr = 1'b0;
    endtask

    // Monitor: every grant must match the next expected level (R2, R9 ordering).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && grant_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected grant", grant_level, -1);
            end else begin
                automatic int e = exp_q.pop_front();
                chk(grant_level == e, "R2 grant order", grant_level, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {emu_req, rst_req, wdog_nmi, pin_nmi, sw_nmi, exc_strobe} = '0;
        irq_in = '0; en_wr = 1'b0; en_wdata = '0; ret_pulse = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(grant_valid == 1'b0, "R1 no grant in reset", grant_valid, 0);
        chk(active_levels == 16'h0, "R1 active clear in reset", active_levels, 0);

        push(1);                       // R1 reset event granted first
        @(posedge clk); #1 rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(active_levels == 16'h0002, "R6 reset level active", active_levels, 2);
        chk(cur_valid && cur_level == 4'd1, "R6 cur_level after reset", cur_level, 1);
        do_ret();
        tick();
        @(negedge clk);
        chk(active_levels == 16'h0, "R7 return clears level", active_levels, 0);

        // R8: enables are 0 out of reset, request waits until enabled.
        pulse_irq(0);
        repeat (3) tick();
        push(7);
        write_en(9'h1FF);
        tick();
        do_ret();

        // R2 R9 R10: all nine lines together, served in level order.
        for (int l = 7; l <= 15; l++) push(l);
        tick();
        irq_in = 9'h1FF;
        tick();
        irq_in = '0;
        for (int k = 0; k < 9; k++) begin
            do_ret();
            tick();
        end
        @(negedge clk);
        chk(active_levels == 16'h0, "R9 all general levels retired", active_levels, 0);
        chk(exp_q.size() == 0, "R10 nine grants seen", exp_q.size(), 0);

        // R5 R6: nesting and blocked lower priority.
        push(12); pulse_irq(5);
        push(9);  pulse_irq(2);
        pulse_irq(3);                  // level 10 must wait behind 9
        tick();
        @(negedge clk);
        chk(active_levels == 16'h1200, "R6 nested active set", active_levels, 16'h1200);
        chk(cur_level == 4'd9, "R5 cur_level is preempting level", cur_level, 9);
        chk(exp_q.size() == 0, "R5 level 10 held pending", exp_q.size(), 0);
        push(10);
        do_ret();
        tick();
        @(negedge clk);
        chk(cur_level == 4'd10, "R7 pending level granted after return", cur_level, 10);
        do_ret();
        do_ret();
        tick();

        // R3: each NMI source, with all general enables off.
        write_en(9'h000);
        for (int s = 0; s < 3; s++) begin
            push(2);
            tick();
            if (s == 0) wdog_nmi = 1'b1;
            if (s == 1) pin_nmi  = 1'b1;
            if (s == 2) sw_nmi   = 1'b1;
            tick();
            {wdog_nmi, pin_nmi, sw_nmi} = '0;
            do_ret();
            tick();
        end
        write_en(9'h1FF);

        // R4: exception accepted in the cycle it is raised.
        push(12); pulse_irq(5);
        push(3);
        tick();
        exc_strobe = 1'b1;
        @(negedge clk);
        chk(grant_valid && grant_level == 4'd3, "R4 exception same cycle", grant_level, 3);
        tick();
        exc_strobe = 1'b0;
        tick();
        @(negedge clk);
        chk(active_levels == 16'h1008, "R6 exception nested over 12", active_levels, 16'h1008);
        do_ret();
        do_ret();
        tick();

        // R4 R5: exception blocked while NMI is active.
        push(2);
        tick(); wdog_nmi = 1'b1; tick(); wdog_nmi = 1'b0;
        tick();
        exc_strobe = 1'b1;
        @(negedge clk);
        chk(grant_valid == 1'b0, "R5 exception blocked by NMI", grant_valid, 0);
        tick();
        exc_strobe = 1'b0;
        push(3);
        do_ret();
        tick();
        do_ret();
        tick();

        // R2: simultaneous fixed classes.
        push(0); push(1); push(2); push(3);
        tick();
        emu_req = 1'b1; rst_req = 1'b1; pin_nmi = 1'b1; exc_strobe = 1'b1;
        tick();
        {emu_req, rst_req, pin_nmi, exc_strobe} = '0;
        for (int k = 0; k < 4; k++) begin
            do_ret();
            tick();
        end
        repeat (3) tick();
        @(negedge clk);
        chk(active_levels == 16'h0, "R7 stack empty at end", active_levels, 0);
        chk(exp_q.size() == 0, "R9 every expected grant seen", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule